// File: doc/BRIEF.md
# DRAM Refresh Scheduler (CAS-before-RAS and RAS-only)

This block runs next to the access engine of an asynchronous DRAM controller and keeps every row of the array refreshed. An interval timer adds one owed refresh per period. Whenever refreshes are owed, the block asks the access engine for the memory pins with a request/grant handshake. Once it holds the grant it plays out one refresh cycle on the row strobe, both byte column strobes and the write strobe. In CAS-before-RAS mode the DRAM's own counter supplies the row. In RAS-only mode the block drives a row number from its own counter.

After reset the block first waits out the power-up pause, then runs a burst of wake-up refresh cycles, and only then tells the access engine it may use the memory. Owed refreshes are counted up to a limit. If the access engine holds the pins so long that a further period ends at the limit, the retention interval is treated as broken. The block then sets a sticky flag, withdraws the ready indication and runs the wake-up burst again. All pulse widths are given in nanoseconds and converted to clock counts at elaboration.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is applied (synchronous, active low) ras_n, casl_n, cash_n and we_n are 1, and ref_req, drive_en, addr_en, ready and overflow are 0.
- R2: No row strobe falls during the first ceil(WAKE_NS/CLK_NS) cycles after reset. WAKE_CYCLES (8) refresh cycles then run, and ready rises when the last of them ends.
- R3: Each ceil(REF_NS/CLK_NS) cycles one refresh becomes owed. Owed refreshes that build up while the grant is withheld are all run back to back once it is given, and none beyond them.
- R4: drive_en, and with it any low strobe, occurs only while ref_gnt is 1. ref_req stays 1 from the request until the cycle's last precharge cycle, and falls together with drive_en. Without a grant no row strobe falls.
- R5: In CAS-before-RAS mode (cbr_mode = 1) casl_n and cash_n are both 0 for at least ceil(CSR_NS/CLK_NS) cycles before ras_n falls and stay 0 until ras_n rises. addr_en is 0.
- R6: In RAS-only mode (cbr_mode = 0) casl_n and cash_n stay 1 and addr_en is 1 while ras_n is low. row_addr equals the internal row count, which advances by one modulo 2^ROW_BITS (511 wraps to 0) after each RAS-only cycle and never after a CAS-before-RAS cycle.
- R7: Before ras_n falls the block has driven the pins, with we_n at 1, for at least ceil(WSU_NS/CLK_NS) cycles, and we_n stays 1 throughout the low row strobe.
- R8: ras_n stays low for at least the largest of the ceilings of RAS_NS, CHR_NS and WRH_NS over CLK_NS. After it rises all strobes stay high and driven for ceil(RP_NS/CLK_NS) cycles before drive_en falls. Every count is rounded up and is at least 1.
- R9: When a period ends while MAX_PEND refreshes are already owed, overflow is set and stays set until reset. ready falls in the same cycle, the owed count is dropped, and exactly WAKE_CYCLES refresh cycles run before ready rises again.
- R10: cbr_mode is sampled when the grant is accepted and holds for that whole refresh cycle. A change while a cycle runs takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cbr_mode | input | 1 | 1 selects CAS-before-RAS refresh, 0 selects RAS-only |
| ref_gnt | input | 1 | Access engine has released the memory pins |
| ref_req | output | 1 | Block wants or holds the memory pins |
| drive_en | output | 1 | Block's strobe values should be driven onto the pins |
| ras_n | output | 1 | Row strobe, active low |
| casl_n | output | 1 | Lower byte column strobe, active low |
| cash_n | output | 1 | Upper byte column strobe, active low |
| we_n | output | 1 | Write strobe, active low (held high by this block) |
| addr_en | output | 1 | row_addr should be driven onto the address pins |
| row_addr | output | ROW_BITS | Row number for RAS-only refresh |
| ready | output | 1 | Wake-up complete, access engine may use the memory |
| overflow | output | 1 | Sticky: owed refreshes went past the limit |

## Verification
The hardest state to reach is the overflow, which only comes from starving the block of its grant across more than MAX_PEND interval ends. The interval timer starts at a fixed cycle after reset, so the bench counts cycles from reset and withholds the grant from the middle of an interval. It checks that overflow is still 0 after MAX_PEND periods and is 1 one period later. It then counts the refresh cycles until ready returns. The owed-refresh test uses the same alignment: it releases the grant just after a period ends, so the number of back-to-back refreshes is known exactly.

// File: rtl/refresh_pkg.sv
// Shared types and elaboration helpers for the refresh scheduler.
// Assumes all timing inputs are non-negative nanosecond values.
package refresh_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_REQ    = 3'd1,
        SQ_GUARD  = 3'd2,
        SQ_SETUP  = 3'd3,
        SQ_ACTIVE = 3'd4,
        SQ_PRECH  = 3'd5
    } seq_state_t;

    // Nanoseconds to clock cycles, rounded up, never below one cycle.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    // Largest of three counts.
    function automatic int unsigned max3(input int unsigned a, input int unsigned b, input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/refresh_timer.sv
// Power-up pause and refresh interval timer.
// Counts T_WAKE cycles after reset and pulses wait_done once. It then
// pulses tick every T_REF cycles. Assumes T_WAKE and T_REF are at least 1.
module refresh_timer #(
    parameter int unsigned T_WAKE = 10000,
    parameter int unsigned T_REF  = 1560
) (
    input  logic clk,
    input  logic rst_n,
    output logic wait_done,
    output logic tick
);
    localparam int unsigned WCW = $clog2(T_WAKE + 1);
    localparam int unsigned ICW = $clog2(T_REF + 1);

    logic           waiting;
    logic [WCW-1:0] wcnt;
    logic [ICW-1:0] icnt;

    assign wait_done = waiting && (wcnt == WCW'(T_WAKE - 1));
    assign tick      = !waiting && (icnt == ICW'(T_REF - 1));

    // Power-up pause counter, then free-running interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting <= 1'b1;
            wcnt    <= '0;
            icnt    <= '0;
        end else if (waiting) begin
            if (wait_done) begin
                waiting <= 1'b0;
                wcnt    <= '0;
            end else begin
                wcnt <= wcnt + 1'b1;
            end
        end else begin
            icnt <= tick ? '0 : icnt + 1'b1;
        end
    end
endmodule

// File: rtl/refresh_ledger.sv
// Bookkeeping of owed refreshes.
// Holds the wake-up burst count and the owed count from interval ticks.
// It raises a sticky overflow when a tick arrives with MAX_PEND already
// owed. A completed cycle is charged to the burst first, then to the owed count.
module refresh_ledger #(
    parameter int unsigned WAKE_CYCLES = 8,
    parameter int unsigned MAX_PEND    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_done,
    input  logic tick,
    input  logic done,
    output logic need,
    output logic ready,
    output logic overflow
);
    localparam int unsigned BW = $clog2(WAKE_CYCLES + 1);
    localparam int unsigned PW = $clog2(MAX_PEND + 1);

    logic [BW-1:0] burst;
    logic [PW-1:0] pend;
    logic          woken;
    logic          dec_b;
    logic          dec_p;
    logic          full;

    // Decide which counter a finished cycle pays off and whether a tick overflows.
    always_comb begin
        dec_b = done && (burst != '0);
        dec_p = done && (burst == '0) && (pend != '0);
        full  = tick && !dec_p && (pend == PW'(MAX_PEND));
    end

    // Burst, owed count, wake flag and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst    <= '0;
            pend     <= '0;
            woken    <= 1'b0;
            overflow <= 1'b0;
        end else if (wait_done) begin
            woken <= 1'b1;
            burst <= BW'(WAKE_CYCLES);
        end else if (full) begin
            overflow <= 1'b1;
            burst    <= BW'(WAKE_CYCLES);
            pend     <= '0;
        end else begin
            if (dec_b) begin
                burst <= burst - 1'b1;
            end
            if (tick && !dec_p) begin
                pend <= pend + 1'b1;
            end else if (!tick && dec_p) begin
                pend <= pend - 1'b1;
            end
        end
    end

    assign need  = (burst != '0) || (pend != '0);
    assign ready = woken && (burst == '0);
endmodule

// File: rtl/refresh_row_ctr.sv
// Row counter for RAS-only refresh. It advances by one on each step and
// wraps at 2^ROW_BITS with no gap.
module refresh_row_ctr #(
    parameter int unsigned ROW_BITS = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    output logic [ROW_BITS-1:0] row
);
    // Increment on each finished RAS-only cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
        end else if (step) begin
            row <= row + 1'b1;
        end
    end
endmodule

// File: rtl/refresh_seq.sv
// Refresh cycle sequencer.
// Requests the pins and waits for the grant, latching the mode with it.
// It then runs guard, strobe setup, row strobe low and precharge, each
// for a fixed cycle count. Assumes the grant stays high while ref_req is high.
// Outputs are decoded from the registered state only.
module refresh_seq
    import refresh_pkg::*;
#(
    parameter int unsigned T_WSU = 1,
    parameter int unsigned T_CSR = 1,
    parameter int unsigned T_ASR = 1,
    parameter int unsigned T_RAS = 6,
    parameter int unsigned T_RP  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic need,
    input  logic ref_gnt,
    input  logic cbr_mode,
    output logic ref_req,
    output logic drive_en,
    output logic addr_en,
    output logic ras_n,
    output logic casl_n,
    output logic cash_n,
    output logic we_n,
    output logic done,
    output logic row_step
);
    localparam int unsigned T_MAX = max3(max3(T_WSU, T_CSR, T_ASR), T_RAS, T_RP);
    localparam int unsigned CW    = $clog2(T_MAX + 1);

    seq_state_t    state;
    logic [CW-1:0] cnt;
    logic          use_cbr;
    logic          strobe_phase;

    // Phase sequencing with a shared down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            cnt     <= '0;
            use_cbr <= 1'b1;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (need) state <= SQ_REQ;
                end
                SQ_REQ: begin
                    if (ref_gnt) begin
                        state   <= SQ_GUARD;
                        cnt     <= CW'(T_WSU - 1);
                        use_cbr <= cbr_mode;
                    end
                end
                SQ_GUARD: begin
                    if (cnt == '0) begin
                        state <= SQ_SETUP;
                        cnt   <= use_cbr ? CW'(T_CSR - 1) : CW'(T_ASR - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SQ_SETUP: begin
                    if (cnt == '0) begin
                        state <= SQ_ACTIVE;
                        cnt   <= CW'(T_RAS - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SQ_ACTIVE: begin
                    if (cnt == '0) begin
                        state <= SQ_PRECH;
                        cnt   <= CW'(T_RP - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SQ_PRECH: begin
                    if (cnt == '0) begin
                        state <= SQ_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Pin and handshake decode from the current phase.
    always_comb begin
        strobe_phase = (state == SQ_SETUP) || (state == SQ_ACTIVE);
        ref_req      = (state != SQ_IDLE);
        drive_en     = (state == SQ_GUARD) || strobe_phase || (state == SQ_PRECH);
        ras_n        = (state != SQ_ACTIVE);
        casl_n       = !(use_cbr && strobe_phase);
        cash_n       = !(use_cbr && strobe_phase);
        addr_en      = !use_cbr && strobe_phase;
        we_n         = 1'b1;
        done         = (state == SQ_PRECH) && (cnt == '0);
        row_step     = done && !use_cbr;
    end
endmodule

// File: rtl/dram_refresh_sched.sv
// Top of the refresh scheduler. Converts nanosecond timing into cycle
// counts, rounding each up, and wires the timer, ledger, row counter and
// sequencer together. Assumes clk has period CLK_NS.
module dram_refresh_sched
    import refresh_pkg::*;
#(
    parameter int unsigned CLK_NS      = 10,
    parameter int unsigned REF_NS      = 15600,
    parameter int unsigned WAKE_NS     = 100000,
    parameter int unsigned WAKE_CYCLES = 8,
    parameter int unsigned MAX_PEND    = 4,
    parameter int unsigned ROW_BITS    = 9,
    parameter int unsigned WSU_NS      = 10,
    parameter int unsigned WRH_NS      = 10,
    parameter int unsigned CSR_NS      = 5,
    parameter int unsigned CHR_NS      = 10,
    parameter int unsigned ASR_NS      = 10,
    parameter int unsigned RAS_NS      = 60,
    parameter int unsigned RP_NS       = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cbr_mode,
    input  logic                ref_gnt,
    output logic                ref_req,
    output logic                drive_en,
    output logic                ras_n,
    output logic                casl_n,
    output logic                cash_n,
    output logic                we_n,
    output logic                addr_en,
    output logic [ROW_BITS-1:0] row_addr,
    output logic                ready,
    output logic                overflow
);
    localparam int unsigned T_REF  = ns_to_cyc(REF_NS, CLK_NS);
    localparam int unsigned T_WAKE = ns_to_cyc(WAKE_NS, CLK_NS);
    localparam int unsigned T_WSU  = ns_to_cyc(WSU_NS, CLK_NS);
    localparam int unsigned T_CSR  = ns_to_cyc(CSR_NS, CLK_NS);
    localparam int unsigned T_ASR  = ns_to_cyc(ASR_NS, CLK_NS);
    localparam int unsigned T_RAS  = max3(ns_to_cyc(RAS_NS, CLK_NS),
                                          ns_to_cyc(CHR_NS, CLK_NS),
                                          ns_to_cyc(WRH_NS, CLK_NS));
    localparam int unsigned T_RP   = ns_to_cyc(RP_NS, CLK_NS);

    logic wait_done;
    logic tick;
    logic need;
    logic done;
    logic row_step;

    refresh_timer #(.T_WAKE(T_WAKE), .T_REF(T_REF)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_done (wait_done),
        .tick      (tick)
    );

    refresh_ledger #(.WAKE_CYCLES(WAKE_CYCLES), .MAX_PEND(MAX_PEND)) u_ledger (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_done (wait_done),
        .tick      (tick),
        .done      (done),
        .need      (need),
        .ready     (ready),
        .overflow  (overflow)
    );

    refresh_row_ctr #(.ROW_BITS(ROW_BITS)) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (row_step),
        .row   (row_addr)
    );

    refresh_seq #(
        .T_WSU (T_WSU),
        .T_CSR (T_CSR),
        .T_ASR (T_ASR),
        .T_RAS (T_RAS),
        .T_RP  (T_RP)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .need     (need),
        .ref_gnt  (ref_gnt),
        .cbr_mode (cbr_mode),
        .ref_req  (ref_req),
        .drive_en (drive_en),
        .addr_en  (addr_en),
        .ras_n    (ras_n),
        .casl_n   (casl_n),
        .cash_n   (cash_n),
        .we_n     (we_n),
        .done     (done),
        .row_step (row_step)
    );
endmodule

// File: rtl/refresh_sched_checker.sv
// Protocol checker for the refresh scheduler, attached by bind.
// Observes only the top-level ports.
module refresh_sched_checker #(
    parameter int unsigned ROW_BITS = 9,
    parameter int unsigned T_RAS    = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cbr_mode,
    input logic                ref_gnt,
    input logic                ref_req,
    input logic                drive_en,
    input logic                ras_n,
    input logic                casl_n,
    input logic                cash_n,
    input logic                we_n,
    input logic                addr_en,
    input logic [ROW_BITS-1:0] row_addr,
    input logic                ready,
    input logic                overflow
);
    logic [15:0] ras_lo_cnt;

    // Length of the current low row strobe, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_lo_cnt <= '0;
        end else if (!ras_n) begin
            if (ras_lo_cnt != 16'hFFFF) ras_lo_cnt <= ras_lo_cnt + 1'b1;
        end else begin
            ras_lo_cnt <= '0;
        end
    end

    assert_drive_needs_gnt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> ref_gnt);
    assert_req_until_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_req) |-> $fell(drive_en));
    assert_ras_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> drive_en);
    assert_cas_vs_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> ((casl_n == cash_n) && (casl_n == addr_en)));
    assert_cas_before_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !addr_en) |-> $past(!casl_n && !cash_n));
    assert_row_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(row_addr) |-> (row_addr == ROW_BITS'($past(row_addr) + 1'b1)));
    assert_row_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_en |-> $stable(row_addr));
    assert_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ($past(drive_en) && we_n));
    assert_ras_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (ras_lo_cnt >= 16'(T_RAS)));
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    assert_ovf_blocks_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> !ready);
endmodule

bind dram_refresh_sched refresh_sched_checker #(
    .ROW_BITS (ROW_BITS),
    .T_RAS    (T_RAS)
) u_chk (.*);

// File: tb/sim_dram_refresh_sched.sv
// Self-checking bench for the refresh scheduler.
module sim_dram_refresh_sched;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_NS     = 10;
    localparam int REF_NS     = 400;
    localparam int WAKE_NS    = 400;
    localparam int WAKE_CYC   = 8;
    localparam int MAX_PEND   = 4;
    localparam int ROW_BITS   = 9;
    localparam int ROWS       = 1 << ROW_BITS;
    localparam int WD_CYCLES  = 150000;

    function automatic int cyc_up(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int T_REF  = cyc_up(REF_NS);
    localparam int T_WAKE = cyc_up(WAKE_NS);
    localparam int T_WSU  = cyc_up(10);
    localparam int T_CSR  = cyc_up(5);
    localparam int T_RAS  = cyc_up(60);
    localparam int T_RP   = cyc_up(40);

    // Stimulus table: mode per phase, refreshes to observe, expected row advance.
    localparam int NV = 6;
    localparam bit TBL_MODE [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam int TBL_CNT  [NV] = '{3, 5, 2, 520, 2, 3};
    localparam int TBL_DROW [NV] = '{0, 5, 0, 520, 0, 3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cbr_mode = 1'b1;
    logic ref_gnt = 1'b0;
    logic gnt_en = 1'b1;
    logic ref_req, drive_en, ras_n, casl_n, cash_n, we_n, addr_en, ready, overflow;
    logic [ROW_BITS-1:0] row_addr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int nfall = 0;
    int first_fall_cyc = -1;
    int exp_row = 0;
    bit finished = 1'b0;
    event ev_fall, ev_drv_fall;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_refresh_sched #(
        .CLK_NS(CLK_NS), .REF_NS(REF_NS), .WAKE_NS(WAKE_NS),
        .WAKE_CYCLES(WAKE_CYC), .MAX_PEND(MAX_PEND), .ROW_BITS(ROW_BITS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cbr_mode(cbr_mode), .ref_gnt(ref_gnt),
        .ref_req(ref_req), .drive_en(drive_en), .ras_n(ras_n),
        .casl_n(casl_n), .cash_n(cash_n), .we_n(we_n), .addr_en(addr_en),
        .row_addr(row_addr), .ready(ready), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Cycle count since reset release.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Access engine model: grants a pending request, keeps a grant while requested.
    always @(negedge clk) begin
        ref_gnt <= ref_req && (gnt_en || ref_gnt);
    end

    // Pin monitor.
    bit prev_ras = 1'b1, prev_drv = 1'b0, cur_cbr = 1'b1, ras_ok = 1'b1;
    int drv_cnt = 0, cas_lo_cnt = 0, ras_lo_cnt = 0, post_cnt = 0, gnt_viol = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (drive_en && !ref_gnt) gnt_viol++;
            if (drive_en && !prev_drv) begin
                cur_cbr = cbr_mode;
                drv_cnt = 0;
            end
            if (prev_ras && !ras_n) begin
                if (nfall == 0) first_fall_cyc = cyc;
                nfall++;
                chk(drv_cnt >= T_WSU, "R7 pins driven before row strobe", drv_cnt, T_WSU);
                chk(we_n == 1'b1, "R7 we_n high at row strobe", we_n, 1);
                if (cur_cbr) begin
                    chk(!casl_n && !cash_n && !addr_en, "R5 CBR strobes/R10 mode",
                        {casl_n, cash_n, addr_en}, 0);
                    chk(cas_lo_cnt >= T_CSR, "R5 CAS setup cycles", cas_lo_cnt, T_CSR);
                end else begin
                    chk(casl_n && cash_n && addr_en, "R6 RAS-only strobes/R10 mode",
                        {casl_n, cash_n, addr_en}, 7);
                    chk(int'(row_addr) == exp_row, "R6 row address", row_addr, exp_row);
                    exp_row = (exp_row + 1) % ROWS;
                end
                ras_ok = 1'b1;
                ras_lo_cnt = 0;
                -> ev_fall;
            end
            if (!ras_n) begin
                ras_lo_cnt++;
                if (cur_cbr && (casl_n || cash_n)) ras_ok = 1'b0;
                if (!we_n || !drive_en) ras_ok = 1'b0;
            end
            if (!prev_ras && ras_n) begin
                chk(ras_lo_cnt >= T_RAS, "R8 row strobe width", ras_lo_cnt, T_RAS);
                chk(ras_ok, "R5 R7 R10 strobes held through row strobe", ras_ok, 1);
                post_cnt = 1;
            end else if (ras_n && drive_en && prev_drv) begin
                post_cnt++;
                if (!casl_n || !cash_n) ras_ok = 1'b0;
            end
            if (prev_drv && !drive_en) begin
                chk(post_cnt >= T_RP, "R8 precharge cycles", post_cnt, T_RP);
                chk(!ref_req, "R4 request falls with drive", ref_req, 0);
                -> ev_drv_fall;
            end
            if (drive_en) drv_cnt++;
            if (!casl_n && !cash_n) cas_lo_cnt++;
            else                    cas_lo_cnt = 0;
            prev_ras = ras_n;
            prev_drv = drive_en;
        end
    end

    task automatic wait_ready();
        while (!ready) @(negedge clk);
    endtask

    task automatic wait_mid();
        do @(negedge clk); while ((cyc % T_REF) != T_REF / 2);
    endtask

    // Watchdog.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int n0;
        int base;
        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ras_n && casl_n && cash_n && we_n, "R1 strobes high in reset",
            {ras_n, casl_n, cash_n, we_n}, 15);
        chk(!ref_req && !drive_en && !addr_en, "R1 no request in reset",
            {ref_req, drive_en, addr_en}, 0);
        chk(!ready && !overflow, "R1 ready/overflow low in reset", {ready, overflow}, 0);
        rst_n = 1'b1;

        // R2: power-up pause then wake-up burst.
        wait_ready();
        chk(nfall == WAKE_CYC, "R2 wake-up refresh count", nfall, WAKE_CYC);
        chk(first_fall_cyc >= T_WAKE, "R2 pause before first refresh", first_fall_cyc, T_WAKE);
        chk(!overflow, "R9 no overflow after wake", overflow, 0);

        // Table walk over modes and row progress (R5, R6, R10).
        for (int v = 0; v < NV; v++) begin
            @(ev_fall);
            cbr_mode = TBL_MODE[v];
            @(ev_drv_fall);
            base = int'(row_addr);
            repeat (TBL_CNT[v]) @(ev_fall);
            @(ev_drv_fall);
            chk(int'(row_addr) == (base + TBL_DROW[v]) % ROWS, "R6 row advance per phase",
                row_addr, (base + TBL_DROW[v]) % ROWS);
        end
        chk(gnt_viol == 0, "R4 pins driven only with grant", gnt_viol, 0);

        // R3: owed refreshes pile up while the grant is withheld.
        repeat (3 * T_REF) @(negedge clk);
        wait_mid();
        chk(!ref_req && !drive_en, "R3 caught up at mid interval", {ref_req, drive_en}, 0);
        gnt_en = 1'b0;
        n0 = nfall;
        repeat (T_REF + T_REF / 2 + 3) @(negedge clk);
        chk(nfall == n0, "R4 no refresh without grant", nfall - n0, 0);
        chk(ref_req == 1'b1, "R4 request held while waiting", ref_req, 1);
        cbr_mode = 1'b1;
        gnt_en = 1'b1;
        repeat (T_REF - 8) @(negedge clk);
        chk(nfall - n0 == 2, "R3 owed refreshes run back to back", nfall - n0, 2);
        chk(!overflow, "R9 no overflow below limit", overflow, 0);

        // R9: overflow after MAX_PEND+1 withheld periods, then wake-up rerun.
        repeat (2 * T_REF) @(negedge clk);
        wait_mid();
        gnt_en = 1'b0;
        repeat (MAX_PEND * T_REF) @(negedge clk);
        chk(!overflow && ready, "R9 at limit without overflow", {overflow, ready}, 1);
        repeat (T_REF) @(negedge clk);
        chk(overflow && !ready, "R9 overflow drops ready", {overflow, ready}, 2);
        n0 = nfall;
        gnt_en = 1'b1;
        wait_ready();
        chk(nfall - n0 == WAKE_CYC, "R9 wake-up burst rerun", nfall - n0, WAKE_CYC);
        repeat (T_REF) @(negedge clk);
        chk(overflow, "R9 overflow sticky", overflow, 1);
        chk(gnt_viol == 0, "R4 pins driven only with grant", gnt_viol, 0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule